// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block produces one pulse-width-modulated signal for a display backlight and a separate backlight enable line. Software sets it up through a byte-wide register port: a write strobe with an 8-bit address and 8-bit data. A combinational read path returns the register selected by the address bus. A base clock tick input, asserted for one clock cycle per base-clock period, feeds a prescaler with a ratio from 1 to 128. Each prescaled step advances an 8-bit period counter, so one PWM period spans 256 steps. The output is high while the counter is below the active duty level.

The block avoids glitches when it is reprogrammed. A new duty level takes effect only at the start of a period. Clearing the output enable returns both the prescaler and the period counter to zero, so the next enable starts a clean period.

Top module: `bl_pwm_top`

## Requirements
- R1: After synchronous reset, all three registers read 0x00, and `pwm_out` and `bl_en_out` are low.
- R2: Address 0x4B is the divider register. Its bit 7 is the PWM output enable and bits 6:0 hold the prescale ratio minus one. Address 0x4E is the 8-bit duty level. Address 0x51 holds the backlight enable in bit 0. The divider and duty registers read back exactly as written. The backlight register reads back bit 0, with bits 7:1 as zero.
- R3: A write to any other address changes nothing, and a read from any other address returns 0x00.
- R4: `pwm_out` is low in every cycle in which the divider enable bit is 0.
- R5: With ratio field d and a base tick in every cycle, each counter step lasts d+1 cycles and a period lasts 256·(d+1) cycles. Within a period the output is high for duty·(d+1) cycles, starting at count 0.
- R6: A duty of 0x00 keeps the output low for the whole period. A duty of 0xFF keeps it high for 255 of the 256 steps.
- R7: A duty write made in the middle of a period leaves that period unchanged. The new level applies from the next period.
- R8: Clearing the enable bit resets the prescaler and the period counter. The next enable begins at count 0 with the current duty level.
- R9: The prescaler and period counter advance only in cycles where `base_tick` is high.
- R10: `bl_en_out` follows bit 0 of the backlight register and does not depend on the PWM enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle pulse per base-clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for both write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at `addr` |
| pwm_out | output | 1 | PWM output |
| bl_en_out | output | 1 | Backlight enable output |

## Verification
The bench builds the block with its default widths: an 8-bit duty and period counter and a 7-bit ratio field. With these widths every ratio, from divide-by-1 up to divide-by-128, is reachable within one run. The bench measures whole periods at ratios 1, 2, 4 and 128. It compares the number of high cycles in each period against duty·(ratio). It also checks mid-period duty writes, restart after disable, and a stalled base tick.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 7;
    localparam int DUTY_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t ADDR_DIV  = 8'h4B;
    localparam byte_t ADDR_DUTY = 8'h4E;
    localparam byte_t ADDR_BL   = 8'h51;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] ratio_m1;
    } divcfg_t;

    typedef struct packed {
        divcfg_t           divcfg;
        logic [DUTY_W-1:0] duty;
        logic              bl;
    } cfg_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DIV,
        SEL_DUTY,
        SEL_BL
    } sel_e;

    function automatic sel_e decode_addr(byte_t a);
        sel_e s;
        case (a)
            ADDR_DIV:  s = SEL_DIV;
            ADDR_DUTY: s = SEL_DUTY;
            ADDR_BL:   s = SEL_BL;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t addr,
    input  byte_t wdata,
    output byte_t rdata,
    output cfg_t  cfg
);

    sel_e sel;

    assign sel = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIV:  cfg.divcfg <= divcfg_t'(wdata);
                SEL_DUTY: cfg.duty   <= wdata;
                SEL_BL:   cfg.bl     <= wdata[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_DIV:  rdata = byte_t'(cfg.divcfg);
            SEL_DUTY: rdata = cfg.duty;
            SEL_BL:   rdata = {{(DATA_W-1){1'b0}}, cfg.bl};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler #(
    parameter int RATIO_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               base_tick,
    input  logic [RATIO_W-1:0] ratio_m1,
    output logic               step
);

    logic [RATIO_W-1:0] cnt;
    logic               at_end;

    assign at_end = (cnt >= ratio_m1);
    assign step   = en && base_tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (base_tick) begin
            cnt <= at_end ? '0 : cnt + RATIO_W'(1);
        end
    end

endmodule

// File: rtl/bl_pwm_period.sv
module bl_pwm_period #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             step,
    input  logic [CNT_W-1:0] duty_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_duty,
    output logic             pwm
);

    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            act_duty <= '0;
        end else if (!en) begin
            cnt      <= '0;
            act_duty <= duty_in;
        end else if (step) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == CNT_LAST) begin
                act_duty <= duty_in;
            end
        end
    end

    assign pwm = en && (cnt < act_duty);

endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       pwm_out,
    output logic       bl_en_out
);

    cfg_t              cfg;
    logic              step;
    logic [DUTY_W-1:0] pcnt;
    logic [DUTY_W-1:0] act_duty;

    bl_pwm_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cfg   (cfg)
    );

    bl_pwm_prescaler #(.RATIO_W(DIV_W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.divcfg.en),
        .base_tick (base_tick),
        .ratio_m1  (cfg.divcfg.ratio_m1),
        .step      (step)
    );

    bl_pwm_period #(.CNT_W(DUTY_W)) u_period (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg.divcfg.en),
        .step     (step),
        .duty_in  (cfg.duty),
        .cnt      (pcnt),
        .act_duty (act_duty),
        .pwm      (pwm_out)
    );

    assign bl_en_out = cfg.bl;

endmodule

// File: rtl/bl_pwm_checker.sv
module bl_pwm_checker
    import bl_pwm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              base_tick,
    input logic              wr_en,
    input logic [7:0]        addr,
    input logic              wdata_b0,
    input logic              wdata_b7,
    input logic [7:0]        rdata,
    input logic              pwm_out,
    input logic              bl_en_out,
    input logic              en,
    input logic [DUTY_W-1:0] pcnt,
    input logic [DUTY_W-1:0] act_duty
);

    logic div_wr;
    assign div_wr = wr_en && (addr == ADDR_DIV);

    AST_RESET_OUT: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pwm_out && !bl_en_out)); // R1

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> (en == $past(wdata_b7))); // R2

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
        (decode_addr(addr) == SEL_NONE) |-> (rdata == 8'h00)); // R3

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm_out); // R4

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (act_duty == '0) |-> !pwm_out); // R6

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && pcnt != '0) |-> $stable(act_duty)); // R7

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pcnt == '0)); // R8

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !base_tick && !div_wr) |=> $stable(pcnt)); // R9

    AST_BL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_BL) |=> (bl_en_out == $past(wdata_b0))); // R10

endmodule

bind bl_pwm_top bl_pwm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .base_tick (base_tick),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata_b0  (wdata[0]),
    .wdata_b7  (wdata[7]),
    .rdata     (rdata),
    .pwm_out   (pwm_out),
    .bl_en_out (bl_en_out),
    .en        (cfg.divcfg.en),
    .pcnt      (pcnt),
    .act_duty  (act_duty)
);

// File: tb/tb_bl_pwm_top.sv
`timescale 1ns/1ps
module tb_bl_pwm_top;

    typedef struct {
        string tag;
        int    val;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pwm_out;
    logic       bl_en_out;

    item_t exp_q[$];
    item_t obs_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    bl_pwm_top dut (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .pwm_out   (pwm_out),
        .bl_en_out (bl_en_out)
    );

    // Driver side: expected item, then the observed result.
    task automatic expect_item(string tag, int e);
        item_t it;
        it.tag = tag;
        it.val = e;
        exp_q.push_back(it);
    endtask

    task automatic observe(string tag, int a);
        item_t it;
        it.tag = tag;
        it.val = a;
        obs_q.push_back(it);
    endtask

    // Monitor: pops and compares as results appear.
    initial begin
        forever begin
            wait (obs_q.size() > 0 && exp_q.size() > 0);
            begin
                item_t e;
                item_t o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                n_checks++;
                if (e.val != o.val) begin
                    n_errors++;
                    $display("FAIL %s actual=%0d expected=%0d", e.tag, o.val, e.val);
                end
            end
        end
    end

    task automatic reg_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = 8'h00;
    endtask

    task automatic reg_read_check(string tag, logic [7:0] a, int e);
        @(negedge clk);
        addr = a;
        #1;
        expect_item(tag, e);
        observe(tag, int'(rdata));
    endtask

    // Count high cycles over n samples, starting at the current negedge.
    // Optionally a duty write is issued at sample inj.
    task automatic measure(string tag, int n, int e, int inj, logic [7:0] inj_duty);
        int high = 0;
        expect_item(tag, e);
        for (int i = 0; i < n; i++) begin
            if (pwm_out) high++;
            if (i == inj) begin
                wr_en = 1'b1;
                addr  = 8'h4E;
                wdata = inj_duty;
            end else if (i == inj + 1) begin
                wr_en = 1'b0;
                addr  = 8'h00;
            end
            @(negedge clk);
        end
        observe(tag, high);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        reg_read_check("R1 div reset", 8'h4B, 0);
        reg_read_check("R1 duty reset", 8'h4E, 0);
        reg_read_check("R1 bl reset", 8'h51, 0);
        expect_item("R1 pwm reset", 0); observe("R1 pwm reset", int'(pwm_out));
        expect_item("R1 bl pin reset", 0); observe("R1 bl pin reset", int'(bl_en_out));

        // R2 readback, R10 backlight
        reg_write(8'h4B, 8'h05);
        reg_read_check("R2 div readback", 8'h4B, 8'h05);
        reg_write(8'h4E, 8'h3C);
        reg_read_check("R2 duty readback", 8'h4E, 8'h3C);
        reg_write(8'h51, 8'hFF);
        reg_read_check("R2 bl readback bit0 only", 8'h51, 1);
        expect_item("R10 bl pin set", 1); observe("R10 bl pin set", int'(bl_en_out));
        measure("R4 pwm low while disabled", 40, 0, -1, 8'h00);

        // R3 unmapped
        reg_write(8'h4C, 8'hAA);
        reg_read_check("R3 unmapped read", 8'h4C, 0);
        reg_read_check("R3 div unchanged", 8'h4B, 8'h05);
        reg_read_check("R3 duty unchanged", 8'h4E, 8'h3C);
        reg_write(8'h51, 8'h00);
        expect_item("R10 bl pin clear", 0); observe("R10 bl pin clear", int'(bl_en_out));

        // R5 ratio 1
        reg_write(8'h4E, 8'h40);
        reg_write(8'h4B, 8'h80);
        measure("R5 ratio1 duty64", 256, 64, -1, 8'h00);
        reg_read_check("R2 div with enable", 8'h4B, 8'h80);

        // R5 ratio 4, R4 disabled low
        reg_write(8'h4B, 8'h03);
        measure("R4 disabled low", 20, 0, -1, 8'h00);
        reg_write(8'h4E, 8'h10);
        reg_write(8'h4B, 8'h83);
        measure("R5 ratio4 duty16", 1024, 64, -1, 8'h00);

        // R6 extremes
        reg_write(8'h4B, 8'h00);
        reg_write(8'h4E, 8'h00);
        reg_write(8'h4B, 8'h80);
        measure("R6 duty zero", 256, 0, -1, 8'h00);
        reg_write(8'h4B, 8'h00);
        reg_write(8'h4E, 8'hFF);
        reg_write(8'h4B, 8'h80);
        measure("R6 duty full", 256, 255, -1, 8'h00);

        // R7 mid-period duty write
        reg_write(8'h4B, 8'h00);
        reg_write(8'h4E, 8'h20);
        reg_write(8'h4B, 8'h81);
        measure("R7 old duty kept", 512, 64, 100, 8'h60);
        measure("R7 new duty next period", 512, 192, -1, 8'h00);

        // R8 restart from zero after disable
        repeat (301) @(negedge clk);
        reg_write(8'h4B, 8'h01);
        measure("R8 low while off", 7, 0, -1, 8'h00);
        reg_write(8'h4B, 8'h81);
        measure("R8 fresh period", 512, 192, -1, 8'h00);

        // R9 stalled base tick
        reg_write(8'h4B, 8'h00);
        reg_write(8'h4E, 8'h01);
        base_tick = 1'b0;
        reg_write(8'h4B, 8'h80);
        measure("R9 frozen without tick", 50, 50, -1, 8'h00);
        base_tick = 1'b1;
        measure("R9 resumes with tick", 256, 1, -1, 8'h00);

        // R5 maximum ratio
        reg_write(8'h4B, 8'h00);
        reg_write(8'h4E, 8'h80);
        reg_write(8'h4B, 8'hFF);
        measure("R5 ratio128 duty128", 32768, 16384, -1, 8'h00);
        reg_read_check("R2 div max readback", 8'h4B, 8'hFF);

        // R10 independence from pwm enable
        reg_write(8'h51, 8'h01);
        reg_write(8'h4B, 8'h7F);
        expect_item("R10 bl stays after pwm off", 1);
        observe("R10 bl stays after pwm off", int'(bl_en_out));
        reg_write(8'h4B, 8'hFF);
        reg_write(8'h51, 8'h00);
        expect_item("R10 bl off pwm on", 0); observe("R10 bl off pwm on", int'(bl_en_out));
        reg_read_check("R10 div untouched by bl", 8'h4B, 8'hFF);

        wait (obs_q.size() == 0 && exp_q.size() == 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule